// File: doc/BRIEF.md
# Strobe-Driven FIFO with Two-Flag Fill Code

This block is a 64-word by 9-bit first-in, first-out store. A producer writes by pulsing a shift-in strobe; a consumer reads by pulsing a shift-out strobe. Both strobes may arrive without any relation to the system clock. Each passes through a two-flop synchronizer and an edge detector, and all storage, pointer and flag logic then runs in the single system clock. An input-ready output tells the producer that there is room. An output-ready output tells the consumer that a valid word waits on the data pins.

The word at the head of the queue is always shown on the data outputs. The first word written into an empty FIFO appears there without a read. A read consumes the shown word and puts the next one in its place. When the last word has been read, that word stays on the pins. An active-low enable drives the data pins or floats them.

Fill level is shown on two flags, `fill_half` and `fill_full`, which form four codes. A small state machine moves between the codes on the rising or falling edges of the strobes. The move points are described below; they are not plain comparisons of the count. The states are FILL_EMPTY (code 00), FILL_LOW (code 10, one to half), FILL_UPPER (code 11, above half) and FILL_TOP (code 01, full). Codes are written as {fill_half, fill_full}.

The transitions are:
- FILL_EMPTY to FILL_LOW when a write completes.
- FILL_LOW to FILL_UPPER on a shift-in rising edge while 32 words are held.
- FILL_UPPER to FILL_TOP on a shift-in rising edge while 63 words are held.
- FILL_TOP to FILL_UPPER when a read completes.
- FILL_UPPER to FILL_LOW on a shift-out rising edge while 33 words are held.
- FILL_LOW to FILL_EMPTY when the count reaches zero.
- A settling move: while both strobes are low, FILL_LOW, FILL_UPPER and FILL_TOP move to the state that the count implies.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low, the read and write positions return to the first slot, `dout` is 0 (with `oe_n` low), `in_ready` is 1, and `out_ready`, `fill_half` and `fill_full` are 0.
- R2: A word is stored when its shift-in strobe falls, with `din` sampled at that edge. Words leave in the order in which they were written.
- R3: A word written into an empty FIFO appears on `dout` after its shift-in strobe falls, and `out_ready` goes to 1, while `shift_out` stays low.
- R4: Starting empty, `fill_half` rises when the first shift-in strobe falls. The code becomes {1,0}.
- R5: Starting empty with no reads, `fill_full` rises on the rising edge of the 33rd shift-in strobe, while that strobe is still high. The code becomes {1,1}.
- R6: On the rising edge of the 64th shift-in strobe, `fill_half` falls. The code becomes {0,1}. Once 64 words are held, `in_ready` is 0.
- R7: A shift-in pulse while 64 words are held writes nothing. That word never appears on `dout`.
- R8: While `shift_out` is high, `out_ready` is 0. After `shift_out` falls, the next word is on `dout`, and `out_ready` is 1 if words remain.
- R9: After the last word is read, `out_ready` stays 0 and `dout` keeps that last word. The code returns to {0,0}.
- R10: From full, the fall of the first shift-out strobe raises `fill_half`. The code becomes {1,1}.
- R11: With 33 words held, `fill_full` falls on the rising edge of the next shift-out strobe. The code becomes {1,0}.
- R12: `oe_n` high puts `dout` in high impedance. `oe_n` low drives the held word.
- R13: A shift-in fall and a shift-out fall detected in the same clock both take effect. The count is unchanged and order is kept. With one word held, the newly written word goes straight to `dout`.
- R14: When both strobes are low, the fill code settles to the code that the count implies (for example {1,0} at 32 words).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| shift_in | input | 1 | Write strobe; the write happens when it falls |
| shift_out | input | 1 | Read strobe; high marks the output busy, and the word is taken when it falls |
| din | input | 9 | Write data |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 9 | Head-of-queue data, or high impedance |
| in_ready | output | 1 | 1 while fewer than 64 words are held |
| out_ready | output | 1 | 1 while a word is held and shift-out is low |
| fill_half | output | 1 | Fill code bit: 1 means between one word and 63 words |
| fill_full | output | 1 | Fill code bit: 1 means above half, including full |

## Verification
A write completing and a read completing can land in the same system clock. The same holds for a strobe rising on one port while the other port's strobe falls. The first case is provoked by raising and lowering both strobes on the same clock. This is done once with one word held, where the new word must go straight to the output, and once with several words held. Each result is judged by the data that then appears on `dout`, by `out_ready`, and by a full drain that must return every word in order. The second case is provoked by a complete read placed inside a shift-in pulse that began at 32 words. The flags must show {1,1} during that shift-in pulse and settle to {1,0} once both strobes are low.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_LOW   = 2'd1,
        FILL_UPPER = 2'd2,
        FILL_TOP   = 2'd3
    } fill_state_t;

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise,
    output logic fall,
    output logic held
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], strobe};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
    assign fall = ~sync_q[STAGES-1] & prev_q;
    assign held = prev_q;
endmodule

// File: rtl/strobe_fifo_mem.sv
module strobe_fifo_mem #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/strobe_fifo_flags.sv
module strobe_fifo_flags
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          si_rise,
    input  logic          so_rise,
    input  logic          idle,
    input  logic          rd_ev,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] count_nxt,
    output logic          fill_half,
    output logic          fill_full
);
    fill_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY: begin
                if (count_nxt != '0) state_d = FILL_LOW;
            end
            FILL_LOW: begin
                if (count_nxt == '0)
                    state_d = FILL_EMPTY;
                else if (si_rise && count == CW'(HALF))
                    state_d = FILL_UPPER;
                else if (idle && count > CW'(HALF))
                    state_d = FILL_UPPER;
            end
            FILL_UPPER: begin
                if (si_rise && count == CW'(DEPTH - 1))
                    state_d = FILL_TOP;
                else if (so_rise && count == CW'(HALF + 1))
                    state_d = FILL_LOW;
                else if (idle && count == CW'(DEPTH))
                    state_d = FILL_TOP;
                else if (idle && count <= CW'(HALF))
                    state_d = FILL_LOW;
            end
            FILL_TOP: begin
                if (rd_ev || (idle && count < CW'(DEPTH)))
                    state_d = FILL_UPPER;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            FILL_EMPTY: begin fill_half = 1'b0; fill_full = 1'b0; end
            FILL_LOW:   begin fill_half = 1'b1; fill_full = 1'b0; end
            FILL_UPPER: begin fill_half = 1'b1; fill_full = 1'b1; end
            FILL_TOP:   begin fill_half = 1'b0; fill_full = 1'b1; end
        endcase
    end
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
    parameter int WIDTH       = 9,
    parameter int DEPTH       = 64,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH),
    localparam int CW         = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_in,
    input  logic             shift_out,
    input  logic [WIDTH-1:0] din,
    input  logic             oe_n,
    output logic [WIDTH-1:0] dout,
    output logic             in_ready,
    output logic             out_ready,
    output logic             fill_half,
    output logic             fill_full
);
    logic si_rise, si_fall, si_held;
    logic so_rise, so_fall, so_held;
    logic [CW-1:0]    count_q, count_nxt;
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q, rd_ptr_inc, wr_ptr_inc;
    logic [WIDTH-1:0] dout_q, next_word;
    logic wr_ev, rd_ev, idle;

    strobe_edge #(.STAGES(SYNC_STAGES)) u_si_edge (
        .clk(clk), .rst_n(rst_n), .strobe(shift_in),
        .rise(si_rise), .fall(si_fall), .held(si_held)
    );

    strobe_edge #(.STAGES(SYNC_STAGES)) u_so_edge (
        .clk(clk), .rst_n(rst_n), .strobe(shift_out),
        .rise(so_rise), .fall(so_fall), .held(so_held)
    );

    assign wr_ev = si_fall && (count_q != CW'(DEPTH));
    assign rd_ev = so_fall && (count_q != '0);
    assign idle  = !si_held && !so_held && !si_rise && !so_rise;

    assign rd_ptr_inc = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    assign wr_ptr_inc = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;

    always_comb begin
        count_nxt = count_q;
        if (wr_ev && !rd_ev) count_nxt = count_q + 1'b1;
        if (rd_ev && !wr_ev) count_nxt = count_q - 1'b1;
    end

    strobe_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .wr_en(wr_ev), .wr_addr(wr_ptr_q), .wr_data(din),
        .rd_addr(rd_ptr_inc), .rd_data(next_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            dout_q   <= '0;
        end else begin
            count_q <= count_nxt;
            if (wr_ev) wr_ptr_q <= wr_ptr_inc;
            if (rd_ev) rd_ptr_q <= rd_ptr_inc;
            if (wr_ev && count_q == '0) begin
                dout_q <= din;
            end else if (rd_ev && count_q > CW'(1)) begin
                dout_q <= next_word;
            end else if (rd_ev && wr_ev) begin
                dout_q <= din;
            end
        end
    end

    strobe_fifo_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst_n(rst_n), .si_rise(si_rise), .so_rise(so_rise),
        .idle(idle), .rd_ev(rd_ev), .count(count_q), .count_nxt(count_nxt),
        .fill_half(fill_half), .fill_full(fill_full)
    );

    assign in_ready  = (count_q != CW'(DEPTH));
    assign out_ready = (count_q != '0) && !so_held;
    assign dout      = oe_n ? {WIDTH{1'bz}} : dout_q;
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] count_q,
    input logic          out_ready,
    input logic          in_ready,
    input logic          fill_half,
    input logic          fill_full,
    input logic          rd_ev
);
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_outputs_R1: assert (!out_ready && in_ready && !fill_half && !fill_full);
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CW'(DEPTH) && !rd_ev) |=> count_q == CW'(DEPTH));

    assert_empty_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_half && !fill_full) |-> count_q == '0);

    assert_no_ready_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0) |-> !out_ready);

    assert_top_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_full && !fill_half) |-> count_q >= CW'(DEPTH - 1));

    assert_single_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1)
                 || (count_q + 1'b1 == $past(count_q)));
endmodule

bind strobe_fifo strobe_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .count_q(count_q), .out_ready(out_ready),
    .in_ready(in_ready), .fill_half(fill_half), .fill_full(fill_full), .rd_ev(rd_ev)
);

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shift_in = 1'b0;
    logic       shift_out = 1'b0;
    logic [8:0] din = '0;
    logic       oe_n = 1'b0;
    logic [8:0] dout;
    logic       in_ready, out_ready, fill_half, fill_full;

    int tests = 0;
    int fails = 0;
    logic [8:0] model[$];
    logic [8:0] last_read;

    always #2.5 clk = ~clk;

    strobe_fifo u_strobe_fifo (
        .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .shift_out(shift_out),
        .din(din), .oe_n(oe_n), .dout(dout), .in_ready(in_ready),
        .out_ready(out_ready), .fill_half(fill_half), .fill_full(fill_full)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; shift_in = 1'b0; shift_out = 1'b0;
        wait_n(2);
        rst_n = 1'b1;
        model.delete();
        wait_n(2);
    endtask

    task automatic si_up(input logic [8:0] d);
        din = d; shift_in = 1'b1;
        wait_n(4);
    endtask

    task automatic si_down();
        shift_in = 1'b0;
        if (model.size() < 64) model.push_back(din);
        wait_n(4);
    endtask

    task automatic so_up();
        shift_out = 1'b1;
        wait_n(4);
    endtask

    task automatic so_down();
        shift_out = 1'b0;
        if (model.size() > 0) last_read = model.pop_front();
        wait_n(4);
    endtask

    task automatic write_word(input logic [8:0] d);
        si_up(d); si_down();
    endtask

    task automatic read_and_check(input string req);
        so_up();
        chk(req, "out_ready busy", {15'd0, out_ready}, 16'd0);
        so_down();
        if (model.size() > 0) begin
            chk(req, "next word", {7'd0, dout}, {7'd0, model[0]});
            chk(req, "out_ready after read", {15'd0, out_ready}, 16'd1);
        end else begin
            chk(req, "last word kept", {7'd0, dout}, {7'd0, last_read});
        end
    endtask

    task automatic test_reset();
        do_reset();
        chk("R1", "dout", {7'd0, dout}, 16'd0);
        chk("R1", "in_ready", {15'd0, in_ready}, 16'd1);
        chk("R1", "out_ready", {15'd0, out_ready}, 16'd0);
        chk("R1", "flags", {14'd0, fill_half, fill_full}, 16'd0);
    endtask

    task automatic test_fall_through();
        do_reset();
        write_word(9'h1A5);
        chk("R3", "fall-through data", {7'd0, dout}, 16'h01A5);
        chk("R3", "out_ready", {15'd0, out_ready}, 16'd1);
        chk("R4", "code after first write", {14'd0, fill_half, fill_full}, 16'b10);
        oe_n = 1'b1; wait_n(1);
        chk("R12", "dout floating", {7'd0, dout}, {7'd0, 9'bz});
        oe_n = 1'b0; wait_n(1);
        chk("R12", "dout driven", {7'd0, dout}, 16'h01A5);
    endtask

    task automatic test_drain_last();
        write_word(9'h033);
        read_and_check("R8");
        read_and_check("R9");
        chk("R9", "out_ready stays low", {15'd0, out_ready}, 16'd0);
        chk("R9", "empty code", {14'd0, fill_half, fill_full}, 16'b00);
        chk("R2", "second word read last", {7'd0, last_read}, 16'h0033);
    endtask

    task automatic test_fill_and_flags();
        do_reset();
        for (int i = 0; i < 32; i++) write_word(9'(i + 9'h100));
        chk("R5", "code at 32 words", {14'd0, fill_half, fill_full}, 16'b10);
        si_up(9'h120);
        chk("R5", "code on 33rd rise", {14'd0, fill_half, fill_full}, 16'b11);
        si_down();
        for (int i = 33; i < 63; i++) write_word(9'(i + 9'h100));
        chk("R6", "code at 63 words", {14'd0, fill_half, fill_full}, 16'b11);
        si_up(9'h13F);
        chk("R6", "code on 64th rise", {14'd0, fill_half, fill_full}, 16'b01);
        si_down();
        chk("R6", "in_ready when full", {15'd0, in_ready}, 16'd0);
        si_up(9'h0EE); si_down();
        chk("R7", "in_ready after ignored write", {15'd0, in_ready}, 16'd0);
        chk("R7", "head unchanged", {7'd0, dout}, 16'h0100);
        read_and_check("R10");
        chk("R10", "code after first read", {14'd0, fill_half, fill_full}, 16'b11);
        for (int i = 0; i < 30; i++) read_and_check("R2");
        so_up();
        chk("R11", "code on rise at 33 words", {14'd0, fill_half, fill_full}, 16'b10);
        so_down();
        while (model.size() > 0) read_and_check("R2");
        chk("R7", "last word is 64th", {7'd0, dout}, 16'h013F);
        chk("R9", "empty after drain", {14'd0, fill_half, fill_full}, 16'b00);
    endtask

    task automatic test_concurrent();
        do_reset();
        write_word(9'h011);
        din = 9'h022; shift_in = 1'b1; shift_out = 1'b1; wait_n(4);
        shift_in = 1'b0; shift_out = 1'b0;
        model.push_back(9'h022); last_read = model.pop_front();
        wait_n(4);
        chk("R13", "new word at head", {7'd0, dout}, 16'h0022);
        chk("R13", "out_ready", {15'd0, out_ready}, 16'd1);
        write_word(9'h033);
        write_word(9'h044);
        din = 9'h055; shift_in = 1'b1; shift_out = 1'b1; wait_n(4);
        shift_in = 1'b0; shift_out = 1'b0;
        model.push_back(9'h055); last_read = model.pop_front();
        wait_n(4);
        chk("R13", "head after joint step", {7'd0, dout}, 16'h0033);
        chk("R13", "code unchanged", {14'd0, fill_half, fill_full}, 16'b10);
        while (model.size() > 0) read_and_check("R13");
        chk("R13", "final word", {7'd0, last_read}, 16'h0055);
    endtask

    task automatic test_settle();
        do_reset();
        for (int i = 0; i < 32; i++) write_word(9'(i));
        si_up(9'h0AA);
        chk("R14", "code during pulse", {14'd0, fill_half, fill_full}, 16'b11);
        so_up(); so_down();
        chk("R14", "code still high mid-pulse", {14'd0, fill_half, fill_full}, 16'b11);
        si_down();
        chk("R14", "code settles at 32", {14'd0, fill_half, fill_full}, 16'b10);
        chk("R14", "head word", {7'd0, dout}, 16'h0001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        test_reset();
        test_fall_through();
        test_drain_last();
        test_fill_and_flags();
        test_concurrent();
        test_settle();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule